// File: doc/BRIEF.md
# Two-Stage SCL Rate Generator

This block derives the serial-clock timing base of an I2C master from the peripheral clock. Two software-supplied divisors feed two cascaded counters. A prescale stage divides the peripheral clock by (P+1), where P is a 2-bit value. A base stage then divides that result by (Q+1), where Q is a 6-bit value. Each pass through the base stage is one base interval of N = (P+1)·(Q+1) clock cycles. Twenty-two base intervals make one SCL period, so the SCL frequency is Fclk / (22·(P+1)·(Q+1)). The fastest rate, Fclk/22, occurs when both divisors are zero.

While enabled, the block drives a free-running SCL reference. It is low for the first 11 base intervals of each period and high for the last 11. It also pulses a one-cycle quarter tick at the start of base intervals 0, 5, 11 and 16 of each period, and a bit engine uses this tick to place its SDA changes and samples. Software should change the divisors only while the controller is idle. A change made while running is held off until the current period ends. Deasserting the enable clears all counters, parks SCL high and silences the tick.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, with enable low, scl_ref is 1 and qtr_tick is 0.
- R2: While enable is low, scl_ref stays 1 and qtr_tick stays 0 whatever values div_pre and div_base take.
- R3: Once running, the SCL period is 22·(P+1)·(Q+1) clock cycles, where P = div_pre (2 bits, 0..3) and Q = div_base (6 bits, 0..63). In each period, scl_ref is 0 for the first 11·(P+1)·(Q+1) cycles and 1 for the remaining 11·(P+1)·(Q+1) cycles.
- R4: qtr_tick is high for exactly one cycle at period offsets 0, 5·N, 11·N and 16·N, where N = (P+1)·(Q+1). It is low in every other cycle.
- R5: With P = 0 and Q = 0, the period is 22 cycles and scl_ref changes level every 11 cycles.
- R6: Enable is sampled high at a clock edge. In the cycle after that edge the period starts at offset 0: scl_ref is 0 and qtr_tick is 1. The divisors used are those present at that edge.
- R7: A change of div_pre or div_base while running has no effect until the current period ends. The next period uses the new values.
- R8: Enable is sampled low at a clock edge. From the next cycle, scl_ref is 1 and qtr_tick is 0. On a later enable, the period restarts from offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; clears and parks it when low |
| div_pre | input | 2 | Prescale divisor P; the stage divides by P+1 |
| div_base | input | 6 | Base divisor Q; the stage divides by Q+1 |
| scl_ref | output | 1 | Free-running SCL reference, high while parked |
| qtr_tick | output | 1 | One-cycle pulse at each quarter-phase point |

## Verification
The bench sweeps every prescale value against a spread of base values, from 0 up to the 63 maximum. For each pair it compares both outputs, cycle by cycle over two full periods, with an arithmetic model. An off-by-one in either stage stretches or shrinks every base interval. A swapped cascade or a wrong half point moves the SCL edges, and a misplaced quarter offset shifts a tick. Any of these is caught at the first differing cycle. A divisor change made mid-period catches a design that applies new divisors immediately, because such a design bends the current period. A drop and re-raise of enable catches counters that are not cleared, because the restarted period then does not begin at offset zero.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  localparam int DEF_PRE_W  = 2;
  localparam int DEF_BASE_W = 6;
  localparam int DEF_HALF   = 11;

  // SCL level for a given base-interval index within the period
  function automatic logic level_for(int idx, int half);
    return (idx >= half);
  endfunction

  // Quarter-phase points: start, mid-low, rising edge, mid-high
  function automatic logic is_quarter(int idx, int half);
    return (idx == 0) || (idx == half / 2) || (idx == half) ||
           (idx == half + half / 2);
  endfunction

endpackage

// File: rtl/scl_stage_cnt.sv
module scl_stage_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  assign wrap = adv && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (adv)     cnt <= cnt + W'(1);
  end

  // R3
  stage_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt <= limit);

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
#(
  parameter int HALF = DEF_HALF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        adv,
  input  logic                        run,
  input  logic                        at_start,
  output logic [$clog2(2*HALF)-1:0]   ph,
  output logic                        ph_wrap,
  output logic                        scl,
  output logic                        tick
);

  localparam int PERIOD = 2 * HALF;
  localparam int PW     = $clog2(PERIOD);
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);

  assign ph_wrap = adv && (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ph <= '0;
    else if (clr)      ph <= '0;
    else if (ph_wrap)  ph <= '0;
    else if (adv)      ph <= ph + PW'(1);
  end

  assign scl  = !run || level_for(int'(ph), HALF);
  assign tick = run && at_start && is_quarter(int'(ph), HALF);

  // R3
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PH_LAST);

  // R3
  rise_at_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl) && run) |-> (ph == PW'(HALF)));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_div_pkg::*;
#(
  parameter int PRE_W  = DEF_PRE_W,
  parameter int BASE_W = DEF_BASE_W,
  parameter int HALF   = DEF_HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PRE_W-1:0]  div_pre,
  input  logic [BASE_W-1:0] div_base,
  output logic              scl_ref,
  output logic              qtr_tick
);

  localparam int PW = $clog2(2 * HALF);

  logic              run;
  logic [PRE_W-1:0]  lat_pre;
  logic [BASE_W-1:0] lat_base;
  logic [PRE_W-1:0]  pre_cnt;
  logic [BASE_W-1:0] base_cnt;
  logic              pre_wrap;
  logic              base_wrap;
  logic [PW-1:0]     ph;
  logic              period_end;
  logic              at_start;
  logic              load_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= enable;
  end

  // Divisors are captured while parked and at each period boundary only
  assign load_div = !run || !enable || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_pre  <= '0;
      lat_base <= '0;
    end else if (load_div) begin
      lat_pre  <= div_pre;
      lat_base <= div_base;
    end
  end

  scl_stage_cnt #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!enable),
    .adv   (run),
    .limit (lat_pre),
    .cnt   (pre_cnt),
    .wrap  (pre_wrap)
  );

  scl_stage_cnt #(.W(BASE_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!enable),
    .adv   (pre_wrap),
    .limit (lat_base),
    .cnt   (base_cnt),
    .wrap  (base_wrap)
  );

  assign at_start = (pre_cnt == '0) && (base_cnt == '0);

  scl_phase_seq #(.HALF(HALF)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!enable),
    .adv      (base_wrap),
    .run      (run),
    .at_start (at_start),
    .ph       (ph),
    .ph_wrap  (period_end),
    .scl      (scl_ref),
    .tick     (qtr_tick)
  );

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |=> !qtr_tick);

  // R8
  park_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_ref && !qtr_tick));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run && !period_end) |=> ($stable(lat_pre) && $stable(lat_base)));

  // R6
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !run) |=> (ph == '0 && at_start));

endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] div_pre = '0;
  logic [5:0] div_base = '0;
  logic       scl_ref;
  logic       qtr_tick;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scl_rate_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .div_pre  (div_pre),
    .div_base (div_base),
    .scl_ref  (scl_ref),
    .qtr_tick (qtr_tick)
  );

  function automatic int exp_scl(int m, int n);
    int idx = (m / n) % 22;
    return (idx >= 11) ? 1 : 0;
  endfunction

  function automatic int exp_tick(int m, int n);
    int idx = (m / n) % 22;
    if (m % n != 0) return 0;
    return (idx == 0 || idx == 5 || idx == 11 || idx == 16) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare len cycles starting at offset 0 against the model with interval n
  task automatic run_compare(int n, int len, output int bad_s, output int bad_t,
                             output int first_s, output int first_t);
    bad_s = 0; bad_t = 0; first_s = -1; first_t = -1;
    for (int m = 0; m < len; m++) begin
      @(negedge clk);
      if (int'(scl_ref) != exp_scl(m, n)) begin
        if (bad_s == 0) first_s = m;
        bad_s++;
      end
      if (int'(qtr_tick) != exp_tick(m, n)) begin
        if (bad_t == 0) first_t = m;
        bad_t++;
      end
    end
  endtask

  task automatic sweep_cfg(int a, int b);
    int n = (a + 1) * (b + 1);
    int bs, bt, fs, ft;
    @(negedge clk);
    enable = 1'b0; div_pre = 2'(a); div_base = 6'(b);
    @(negedge clk);
    check(scl_ref == 1'b1 && qtr_tick == 1'b0, "R2", {scl_ref, qtr_tick}, 2, "parked outputs");
    enable = 1'b1;
    run_compare(n, 44 * n, bs, bt, fs, ft);
    check(bs == 0, (a == 0 && b == 0) ? "R5" : "R3", fs, -1,
          $sformatf("scl mismatch cycle (P=%0d Q=%0d)", a, b));
    check(bt == 0, "R4", ft, -1, $sformatf("tick mismatch cycle (P=%0d Q=%0d)", a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bvals[7] = '{0, 1, 2, 3, 7, 31, 63};
    int bs, bt, fs, ft;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_ref == 1'b1 && qtr_tick == 1'b0, "R1", {scl_ref, qtr_tick}, 2, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_ref == 1'b1 && qtr_tick == 1'b0, "R1", {scl_ref, qtr_tick}, 2, "after reset release");

    // R2: divisors wiggle while disabled
    bs = 0;
    for (int k = 0; k < 40; k++) begin
      div_pre = 2'(k); div_base = 6'(k * 7);
      @(negedge clk);
      if (scl_ref != 1'b1 || qtr_tick != 1'b0) bs++;
    end
    check(bs == 0, "R2", bs, 0, "disabled cycles with activity");

    // R6: first cycle after enable
    div_pre = 2'd2; div_base = 6'd3;
    enable = 1'b1;
    @(negedge clk);
    check(scl_ref == 1'b0 && qtr_tick == 1'b1, "R6", {scl_ref, qtr_tick}, 1, "first enabled cycle");
    @(negedge clk);
    check(qtr_tick == 1'b0, "R6", qtr_tick, 0, "tick after first cycle");

    // R3 / R4 / R5: sweep
    for (int a = 0; a < 4; a++)
      for (int j = 0; j < 7; j++)
        sweep_cfg(a, bvals[j]);

    // R7: mid-period divisor change
    @(negedge clk);
    enable = 1'b0; div_pre = 2'd0; div_base = 6'd0;
    @(negedge clk);
    enable = 1'b1;
    bs = 0; bt = 0;
    for (int m = 0; m < 22; m++) begin
      @(negedge clk);
      if (m == 3) begin div_pre = 2'd1; div_base = 6'd1; end
      if (int'(scl_ref) != exp_scl(m, 1)) bs++;
      if (int'(qtr_tick) != exp_tick(m, 1)) bt++;
    end
    check(bs == 0 && bt == 0, "R7", bs + bt, 0, "old-divisor period mismatches");
    run_compare(4, 88, bs, bt, fs, ft);
    check(bs == 0 && bt == 0, "R7", bs + bt, 0, "new-divisor period mismatches");

    // R8: drop enable mid-period and restart
    @(negedge clk);
    enable = 1'b0; div_pre = 2'd0; div_base = 6'd1;
    @(negedge clk);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_ref == 1'b1 && qtr_tick == 1'b0, "R8", {scl_ref, qtr_tick}, 2, "parked after disable");
    enable = 1'b1;
    run_compare(2, 44, bs, bt, fs, ft);
    check(bs == 0 && bt == 0, "R8", bs + bt, 0, "restart mismatches");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule